// File: doc/BRIEF.md
# Maskable Two-Output Interrupt Router

This block is a first-level interrupt controller for a bank of level-sensitive source lines. Each source line passes through a two-flop synchroniser and is then captured in a pending register. A per-source enable register decides which pending sources become active. A per-source steering register sends each active source to one of two processor interrupt lines: the normal request `irq_o` or the fast request `fiq_o`. The block also raises a wake request toward a power manager.

Software reaches the registers through a simple synchronous register bus. A write takes effect at the clock edge where `bus_we` is high. A read returns data on `bus_rdata` one edge after `bus_re` is sampled high, and that value holds until the next read. The `idle_mode` input tells the block that the system is idle. In that state, a control bit decides whether the enable register still gates the wake request.

The word map is fixed. Offset 0x00 is the pending register (read-only). Offset 0x04 is the enable register and 0x08 is the steering register. Offset 0x0C is the fast-active status and 0x10 is the normal-active status, both read-only. Offset 0x14 is the control register, with the idle-gate bit at bit 0. Only source positions 7 through 31 are implemented.

Top module: `irq_router`

## Requirements
- R1: After reset, the enable, steering and control registers read 0, and `irq_o`, `fiq_o` and `wake_o` are low.
- R2: A pending source whose enable bit is 0 drives none of `irq_o`, `fiq_o` or `wake_o`, outside idle mode.
- R3: A pending source that is enabled and has steering bit 0 raises `irq_o`. One that is enabled with steering bit 1 raises `fiq_o`. The outputs follow a register write at the next clock edge.
- R4: Changing the steering bit of a disabled pending source changes neither `irq_o` nor `fiq_o`.
- R5: Bit positions 0 to 6 are reserved. In the enable, steering and pending registers they read 0, and writes to them are ignored. Source lines 0 to 6 never become pending.
- R6: When `idle_mode` is 1 and control bit 0 is 0, any pending source raises `wake_o`, whatever its enable bit. `irq_o` and `fiq_o` still obey the enable bits.
- R7: When `idle_mode` is 1 and control bit 0 is 1, `wake_o` is raised only by enabled pending sources. Outside idle mode, `wake_o` is the OR of all enabled pending sources.
- R8: The pending register reads at 0x00, and writes to it are ignored. The enable register is at 0x04, the steering register at 0x08, and the control register at 0x14, where only bit 0 is kept. The fast-active status at 0x0C reads pending AND enable AND steering. The normal-active status at 0x10 reads pending AND enable AND NOT steering. Unmapped offsets read 0.
- R9: A change on a source line reaches the pending register after three clock edges. It reaches `irq_o`, `fiq_o` and `wake_o` after four clock edges.
- R10: `irq_o` is the OR over all sources that are active and steered to the normal line. `fiq_o` is the same OR over sources steered to the fast line. Both can be high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| idle_mode | input | 1 | System idle indication |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to the power manager |

## Verification
The assertions assume that `bus_we` and `bus_re` are never high at the same time. They also assume that the source lines and `idle_mode` are steady enough for the synchroniser to settle. The stimulus drives every input at the falling clock edge, issues bus accesses one at a time, and holds the source lines steady for several cycles before each output is checked. Under these conditions the properties that link the enable and steering registers to the registered outputs follow directly from one cycle of history.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // word index of each register (byte offset / 4)
  localparam logic [2:0] W_PEND  = 3'd0;
  localparam logic [2:0] W_MASK  = 3'd1;
  localparam logic [2:0] W_STEER = 3'd2;
  localparam logic [2:0] W_FSTAT = 3'd3;
  localparam logic [2:0] W_ISTAT = 3'd4;
  localparam logic [2:0] W_CTRL  = 3'd5;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'b00,
    BUS_WRITE = 2'b01,
    BUS_READ  = 2'b10
  } bus_op_e;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int N  = 32,
  parameter int LO = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] meta_q, sync_q, pend_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i < LO) begin : g_rsv
        assign meta_q[i] = 1'b0;
        assign sync_q[i] = 1'b0;
        assign pend_q[i] = 1'b0;
      end else begin : g_impl
        always_ff @(posedge clk) begin
          if (rst) begin
            meta_q[i] <= 1'b0;
            sync_q[i] <= 1'b0;
            pend_q[i] <= 1'b0;
          end else begin
            meta_q[i] <= src_i[i];
            sync_q[i] <= meta_q[i];
            pend_q[i] <= sync_q[i];
          end
        end
      end
    end
  endgenerate

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int N      = 32,
  parameter int LO     = 7,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N-1:0]      bus_wdata,
  input  logic              bus_re,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      bus_rdata,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      steer_o,
  output logic              gate_idle_o
);
  localparam logic [N-1:0] IMPL = {{(N-LO){1'b1}}, {LO{1'b0}}};

  logic [N-1:0] mask_q, steer_q, rdata_q, rd_mux;
  logic         gate_q;
  logic [2:0]   word;
  bus_op_e      op;

  assign word = bus_addr[4:2];
  always_comb begin
    if (bus_we)      op = BUS_WRITE;
    else if (bus_re) op = BUS_READ;
    else             op = BUS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      steer_q <= '0;
      gate_q  <= 1'b0;
    end else if (op == BUS_WRITE) begin
      case (word)
        W_MASK:  mask_q  <= bus_wdata & IMPL;
        W_STEER: steer_q <= bus_wdata & IMPL;
        W_CTRL:  gate_q  <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (word)
      W_PEND:  rd_mux = pend_i;
      W_MASK:  rd_mux = mask_q;
      W_STEER: rd_mux = steer_q;
      W_FSTAT: rd_mux = pend_i & mask_q & steer_q;
      W_ISTAT: rd_mux = pend_i & mask_q & ~steer_q;
      W_CTRL:  rd_mux = {{(N-1){1'b0}}, gate_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata_q <= '0;
    else if (op == BUS_READ)  rdata_q <= rd_mux;
  end

  assign bus_rdata   = rdata_q;
  assign mask_o      = mask_q;
  assign steer_o     = steer_q;
  assign gate_idle_o = gate_q;

  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((mask_q & ~IMPL) == '0) && ((steer_q & ~IMPL) == '0));

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && word == W_CTRL) |=> $stable(gate_q));
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] steer_i,
  input  logic         idle_i,
  input  logic         gate_idle_i,
  output logic         irq_o,
  output logic         fiq_o,
  output logic         wake_o
);
  logic [N-1:0] act, to_fast, to_norm;

  generate
    for (genvar i = 0; i < N; i++) begin : g_route
      assign act[i]     = pend_i[i] & mask_i[i];
      assign to_fast[i] = act[i] & steer_i[i];
      assign to_norm[i] = act[i] & ~steer_i[i];
    end
  endgenerate

  logic wake_d;
  assign wake_d = (idle_i && !gate_idle_i) ? (|pend_i) : (|act);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |to_norm;
      fiq_o  <= |to_fast;
      wake_o <= wake_d;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N      = 32,
  parameter int LO     = 7,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src_i,
  input  logic              idle_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N-1:0]      bus_wdata,
  input  logic              bus_re,
  output logic [N-1:0]      bus_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);
  logic [N-1:0] pend, mask, steer;
  logic         gate_idle;

  irq_src_sync #(.N(N), .LO(LO)) u_sync (
    .clk(clk), .rst(rst), .src_i(src_i), .pend_o(pend)
  );

  irq_regfile #(.N(N), .LO(LO), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .pend_i(pend),
    .bus_rdata(bus_rdata), .mask_o(mask), .steer_o(steer),
    .gate_idle_o(gate_idle)
  );

  irq_steer #(.N(N)) u_steer (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask), .steer_i(steer),
    .idle_i(idle_mode), .gate_idle_i(gate_idle),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & mask) == '0) |=> (!irq_o && !fiq_o));

  // R3
  fast_route_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & mask & steer) != '0) |=> fiq_o);

  // R10
  norm_route_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & mask & ~steer) != '0) |=> irq_o);

  // R6
  idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_mode && !gate_idle && (pend != '0)) |=> wake_o);

  // R7
  gated_wake_chk: assert property (@(posedge clk) disable iff (rst)
    ((!idle_mode || gate_idle) && ((pend & mask) == '0)) |=> !wake_o);
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_i;
  logic        idle_mode;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, wake_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst(rst), .src_i(src_i), .idle_mode(idle_mode),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {29'd0, wake_o, fiq_o, irq_o};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 outputs", outs(), 32'd0);
    rd(5'h04, d); check("R1 mask", d, 32'd0);
    rd(5'h08, d); check("R1 steer", d, 32'd0);
    rd(5'h14, d); check("R1 ctrl", d, 32'd0);
  endtask

  task automatic t_masked();
    set_src(32'h0000_0100);
    check("R2 masked source quiet", outs(), 32'd0);
  endtask

  task automatic t_route();
    wr(5'h04, 32'h0000_0100);
    @(negedge clk);
    check("R3 irq after enable", outs(), 32'b101);
    wr(5'h08, 32'h0000_0100);
    @(negedge clk);
    check("R3 fiq after steer", outs(), 32'b110);
    wr(5'h08, 32'h0);
    wr(5'h04, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_steer_masked();
    wr(5'h08, 32'h0000_0100);
    @(negedge clk);
    check("R4 steer of masked fiq", outs(), 32'd0);
    wr(5'h08, 32'h0);
    @(negedge clk);
    check("R4 steer of masked irq", outs(), 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d); check("R5 mask reserved", d, 32'hFFFF_FF80);
    wr(5'h08, 32'h0000_007F);
    rd(5'h08, d); check("R5 steer reserved", d, 32'h0);
    set_src(32'h0000_007F);
    rd(5'h00, d); check("R5 low sources not pending", d, 32'h0);
    check("R5 low sources no output", outs(), 32'd0);
    wr(5'h04, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    set_src(32'h8000_0300);
    wr(5'h04, 32'h8000_0200);
    wr(5'h08, 32'h8000_0000);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R8 pending read, write ignored", d, 32'h8000_0300);
    rd(5'h0C, d); check("R8 fast status", d, 32'h8000_0000);
    rd(5'h10, d); check("R8 normal status", d, 32'h0000_0200);
    rd(5'h18, d); check("R8 unmapped", d, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d); check("R8 ctrl bit0 only", d, 32'h1);
    wr(5'h14, 32'h0);
    check("R10 both outputs", outs(), 32'b111);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h0);
    set_src(32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    wr(5'h04, 32'h0001_0000);
    @(negedge clk);
    src_i = 32'h0001_0000;
    repeat (3) @(negedge clk);
    check("R9 no output after three edges", outs(), 32'd0);
    @(negedge clk);
    check("R9 output after four edges", outs(), 32'b101);
    rd(5'h00, d); check("R9 pending", d, 32'h0001_0000);
    wr(5'h04, 32'h0);
    set_src(32'h0);
  endtask

  task automatic t_idle();
    set_src(32'h0000_0800);
    idle_mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 idle wake ignores mask", outs(), 32'b100);
    wr(5'h14, 32'h1);
    @(negedge clk);
    check("R7 idle gated wake low", outs(), 32'd0);
    wr(5'h04, 32'h0000_0800);
    @(negedge clk);
    check("R7 idle gated wake enabled", outs(), 32'b101);
    idle_mode = 1'b0;
    wr(5'h14, 32'h0);
    wr(5'h04, 32'h0);
    repeat (2) @(negedge clk);
    check("R7 active mode masked", outs(), 32'd0);
    set_src(32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        rst = 1'b1; src_i = '0; idle_mode = 1'b0;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_masked();
        t_route();
        t_steer_masked();
        t_reserved();
        t_map();
        t_latency();
        t_idle();
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule